// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block receives register writes over a three-wire serial link: an active-low select, a serial clock and a serial data line. An external host drops the select, sends one 16-bit frame, and raises the select again. The block samples the data on each rising edge of the serial clock and decides whether the frame is valid. If it is, the block issues a one-cycle write strobe with a 5-bit register address and an 8-bit data byte in the system clock domain. Reads are not supported.

All three serial lines are brought into the system clock domain by two-flop synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock, which is at most 5 MHz in normal use. A frame is committed only when the select rises after exactly 16 serial clock rising edges, the two chip-identity bits match the strap inputs, and the direction bit is 1. While the power-down input is high, no write is issued and the write outputs hold their default value of zero.

Top module: `serial_write_port`

## Requirements
- R1: After reset, `wr_stb` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: A frame of exactly 16 serial-clock rising edges while `sel_n` is low gives exactly one `wr_stb` pulse. The bits are taken in order, first received first: identity bit 1, identity bit 0, direction, then 5 address bits MSB first, then 8 data bits MSB first. `wr_addr` and `wr_data` carry those fields while the strobe is high. The pulse comes after the frame is otherwise accepted by R3 to R7.
- R3: A frame with 15 or fewer rising edges produces no strobe.
- R4: A frame with 17 or more rising edges produces no strobe.
- R5: A frame whose two identity bits differ from `id_strap[1:0]` (bit 1 compared with the first bit received) produces no strobe.
- R6: A frame whose direction bit is 0 produces no strobe.
- R7: While `pwr_down` is 1, no strobe is issued, and in the cycle after `pwr_down` is sampled high, `wr_addr` and `wr_data` are zero.
- R8: `wr_stb` is high for exactly one system clock cycle. It rises only after `sel_n` has returned high, within 4 system clocks of that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_down | input | 1 | Power-down: blocks writes and clears the write outputs |
| sel_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| id_strap | input | 2 | Chip-identity straps compared with the frame's first two bits |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the accepted write |
| wr_data | output | 8 | Data byte of the accepted write |

## Verification
The hardest case to reach from the ports is a frame that is correct in every field but has one serial clock edge too few or too many. To produce it, the same field pattern must be driven with different edge counts. The stimulus builds a 32-bit bit pattern for each frame and clocks out a chosen number of its bits. The edge count is drawn from 15, 16 and 17, with occasional much shorter and longer counts. Identity mismatches, a zero direction bit and power-down are mixed in at random, and each case is also forced once as a directed corner case.

// File: rtl/serw_pkg.sv
package serw_pkg;
  localparam int unsigned ID_W     = 2;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FRAME_W  = ID_W + 1 + ADDR_W + DATA_W;
  localparam int unsigned CNT_W    = $clog2(FRAME_W + 2);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              dir;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/serw_sync.sv
module serw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  input  logic [W-1:0] idle_val,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      logic              prev_q;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= {STAGES{idle_val[b]}};
          prev_q  <= idle_val[b];
        end else begin
          chain_q <= chain_d;
          prev_q  <= chain_q[STAGES-1];
        end
      end

      assign lvl[b]  = chain_q[STAGES-1];
      assign rise[b] = chain_q[STAGES-1] & ~prev_q;
      assign fall[b] = ~chain_q[STAGES-1] & prev_q;
    end
  endgenerate
endmodule

// File: rtl/serw_shift.sv
module serw_shift
  import serw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             bit_in,
  output frame_t           word,
  output logic [CNT_W-1:0] edge_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = clr ? '0 : cnt_q;
    if (bit_en) begin
      sr_d = {sr_q[FRAME_W-2:0], bit_in};
      if (cnt_d != CNT_SAT) begin
        cnt_d = cnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (bit_en) begin
        sr_q <= sr_d;
      end
      cnt_q <= cnt_d;
    end
  end

  assign word     = frame_t'(sr_q);
  assign edge_cnt = cnt_q;
endmodule

// File: rtl/serw_commit.sv
module serw_commit
  import serw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              sel_release,
  input  frame_t            word,
  input  logic [CNT_W-1:0]  edge_cnt,
  input  logic [ID_W-1:0]   id_strap,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              frame_ok;
  logic              stb_d, stb_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic              load_en;

  always_comb begin
    frame_ok = (edge_cnt == CNT_W'(FRAME_W)) && (word.id == id_strap)
               && word.dir && !pwr_down;
    stb_d    = sel_release && frame_ok;
    load_en  = stb_d || pwr_down;
    addr_d   = pwr_down ? '0 : word.addr;
    data_d   = pwr_down ? '0 : word.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (load_en) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/serial_write_port.sv
module serial_write_port
  import serw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [ID_W-1:0]   id_strap,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned SEL_B = 2;
  localparam int unsigned SCK_B = 1;
  localparam int unsigned SDI_B = 0;

  logic [2:0]       lvl, rise, fall;
  logic             sel_lvl;
  logic             shift_clr, shift_en;
  frame_t           word;
  logic [CNT_W-1:0] edge_cnt;

  serw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sel_n, sck, sdi}),
    .idle_val (3'b100),
    .lvl      (lvl),
    .rise     (rise),
    .fall     (fall)
  );

  assign sel_lvl   = lvl[SEL_B];
  assign shift_clr = fall[SEL_B] | pwr_down;
  assign shift_en  = rise[SCK_B] & ~sel_lvl & ~pwr_down;

  serw_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (shift_clr),
    .bit_en   (shift_en),
    .bit_in   (lvl[SDI_B]),
    .word     (word),
    .edge_cnt (edge_cnt)
  );

  serw_commit u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down    (pwr_down),
    .sel_release (rise[SEL_B]),
    .word        (word),
    .edge_cnt    (edge_cnt),
    .id_strap    (id_strap),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );
endmodule

// File: rtl/serial_write_port_chk.sv
module serial_write_port_chk
  import serw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              sel_lvl,
  input logic [CNT_W-1:0]  edge_cnt,
  input frame_t            word,
  input logic [ID_W-1:0]   id_strap,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  // R3 and R4: a strobe follows only a 16-edge frame
  a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(edge_cnt) == CNT_W'(FRAME_W));

  // R5
  a_r5_id_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(word.id) == $past(id_strap));

  // R6
  a_r6_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(word.dir));

  // R7
  a_r7_pd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !wr_stb);

  a_r7_pd_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (wr_addr == '0) && (wr_data == '0));

  // R8
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r8_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sel_lvl));

  // R2: fields match the captured frame while strobing
  a_r2_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == $past(word.addr)) && (wr_data == $past(word.data)));
endmodule

bind serial_write_port serial_write_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_down (pwr_down),
  .sel_lvl  (sel_lvl),
  .edge_cnt (edge_cnt),
  .word     (word),
  .id_strap (id_strap),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/serial_write_port_tb_top.sv
module serial_write_port_tb_top;
  logic       clk;
  logic       rst_n;
  logic       pwr_down;
  logic       sel_n;
  logic       sck;
  logic       sdi;
  logic [1:0] id_strap;
  logic       wr_stb;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  int unsigned n_run;
  int unsigned n_fail;
  int unsigned stb_seen;
  logic [4:0]  cap_addr;
  logic [7:0]  cap_data;
  logic        prev_stb;
  int unsigned early_err;
  int unsigned wide_err;
  bit          done;

  serial_write_port dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .sel_n    (sel_n),
    .sck      (sck),
    .sdi      (sdi),
    .id_strap (id_strap),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_seen <= stb_seen + 1;
        cap_addr <= wr_addr;
        cap_data <= wr_data;
        if (!sel_n) early_err <= early_err + 1;
        if (prev_stb) wide_err <= wide_err + 1;
      end
      prev_stb <= wr_stb;
    end
  end

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit expect_write(input int edges, input logic [15:0] fr,
                                      input logic [1:0] strap, input bit pd);
    return (edges == 16) && (fr[15:14] == strap) && fr[13] && !pd;
  endfunction

  function automatic string reason(input int edges, input logic [15:0] fr,
                                   input logic [1:0] strap, input bit pd);
    if (pd) return "R7";
    if (edges < 16) return "R3";
    if (edges > 16) return "R4";
    if (fr[15:14] != strap) return "R5";
    if (!fr[13]) return "R6";
    return "R2";
  endfunction

  task automatic run_frame(input logic [15:0] fr, input logic [15:0] tail,
                           input int edges, input bit pd);
    logic [31:0] pat;
    bit          exp;
    string       tag;
    pat = {fr, tail};
    exp = expect_write(edges, fr, id_strap, pd);
    tag = reason(edges, fr, id_strap, pd);
    @(posedge clk);
    stb_seen = 0;
    @(negedge clk);
    pwr_down = pd;
    wait_clk(2);
    sel_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < edges; i++) begin
      sdi = pat[31-i];
      sck = 1'b0;
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
    end
    sck = 1'b0;
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(8);
    check(tag, stb_seen, exp ? 1 : 0);
    if (exp) begin
      check("R2 addr", cap_addr, fr[12:8]);
      check("R2 data", cap_data, fr[7:0]);
    end
    if (pd) begin
      check("R7 addr default", wr_addr, 0);
      check("R7 data default", wr_data, 0);
    end
    pwr_down = 1'b0;
    wait_clk(2);
  endtask

  function automatic logic [15:0] make_frame(input logic [1:0] id, input bit dir,
                                             input logic [4:0] a, input logic [7:0] d);
    return {id, dir, a, d};
  endfunction

  initial begin
    n_run = 0; n_fail = 0; stb_seen = 0; early_err = 0; wide_err = 0;
    prev_stb = 1'b0; cap_addr = '0; cap_data = '0; done = 1'b0;
    rst_n = 1'b0; pwr_down = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    id_strap = 2'b10;
    void'($urandom(32'h5eed_1234));
    wait_clk(4);
    check("R1 strobe", wr_stb, 0);
    check("R1 addr", wr_addr, 0);
    check("R1 data", wr_data, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // Directed corner cases
    run_frame(make_frame(2'b10, 1'b1, 5'h15, 8'hA5), 16'hFFFF, 16, 1'b0); // R2
    run_frame(make_frame(2'b10, 1'b1, 5'h1F, 8'h00), 16'h0000, 16, 1'b0); // R2
    run_frame(make_frame(2'b10, 1'b1, 5'h03, 8'h3C), 16'h0000, 15, 1'b0); // R3
    run_frame(make_frame(2'b10, 1'b1, 5'h03, 8'h3C), 16'h0000, 1, 1'b0);  // R3
    run_frame(make_frame(2'b10, 1'b1, 5'h03, 8'h3C), 16'h8000, 17, 1'b0); // R4
    run_frame(make_frame(2'b10, 1'b1, 5'h03, 8'h3C), 16'h1234, 30, 1'b0); // R4
    run_frame(make_frame(2'b01, 1'b1, 5'h07, 8'h11), 16'h0000, 16, 1'b0); // R5
    run_frame(make_frame(2'b10, 1'b0, 5'h07, 8'h11), 16'h0000, 16, 1'b0); // R6
    run_frame(make_frame(2'b10, 1'b1, 5'h0A, 8'hC3), 16'h0000, 16, 1'b1); // R7
    id_strap = 2'b01;
    run_frame(make_frame(2'b01, 1'b1, 5'h00, 8'hFF), 16'h0000, 16, 1'b0); // R2

    // Constrained random frames
    for (int t = 0; t < 50; t++) begin
      logic [1:0]  id;
      bit          dir, pd;
      int          edges;
      int unsigned sel;
      id_strap = 2'($urandom_range(0, 3));
      id  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : id_strap;
      dir = ($urandom_range(0, 4) != 0);
      pd  = ($urandom_range(0, 9) == 0);
      sel = $urandom_range(0, 9);
      if (sel < 6) edges = 16;
      else if (sel == 6) edges = 15;
      else if (sel == 7) edges = 17;
      else edges = $urandom_range(1, 31);
      run_frame(make_frame(id, dir, 5'($urandom_range(0, 31)), 8'($urandom_range(0, 255))),
                16'($urandom_range(0, 65535)), edges, pd);
    end

    check("R8 strobe before release", early_err, 0);
    check("R8 strobe wider than one cycle", wide_err, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule